// File: doc/BRIEF.md
# EEPROM Image Programming Sequencer

This block copies an image of 16-bit words from a source read port into a slow EEPROM window. The window is reached through a simple request/acknowledge register and memory write port. A `start_i` pulse latches the word count and the window base address. The sequencer then runs the following steps without further help:

- It reads the control register and writes it back with the write-enable bit set.
- It waits an opening settle time.
- It writes each word to consecutive 16-bit slots, waiting a per-word settle time after each one.
- It reads the control register again and writes it back with write-enable cleared.
- It waits a closing settle time and then signals completion.

All waits are counted in pulses of a millisecond tick input. A tick is counted only while the sequencer is waiting. Ticks that arrive while a bus access is pending are not counted. The three wait lengths are parameters, so a simulation can shorten them. Progress pulses mark the word indices that sit at one quarter, one half and three quarters of the image.

An error response on a control-register access ends the sequence at once. An error on a data write skips the rest of the image and goes straight to clearing write-enable, so the window is not left writable.

Top module: `eeprom_prog_seq`

## Requirements
- R1: While `rst_ni` is low, and after its release with no start, `busy_o`, `done_o`, `err_o`, `bus_req_o` and `milestone_o` are all 0.
- R2: The first access after start is a read of `CTRL_ADDR`. It is followed, with no waiting, by a write to `CTRL_ADDR` of the value read OR `1 << WE_BIT`; every other bit is unchanged.
- R3: After the set write is acknowledged, the next access is issued only after exactly `OPEN_TICKS` ticks, counted while busy and not requesting. That access is the first data write, or the clear read when the count is 0.
- R4: Word i (0 <= i < count) is read from source index i and written to `base + 2*i`, in increasing order of i.
- R5: After each acknowledged data write, exactly `WORD_TICKS` counted ticks pass before the next access.
- R6: After the last word's settle time, `CTRL_ADDR` is read and then written with the read value AND NOT `1 << WE_BIT`. Exactly `CLOSE_TICKS` counted ticks later, `done_o` pulses.
- R7: `milestone_o` bit 0, bit 1 and bit 2 pulse in the cycle after word i is acknowledged, when i equals count/4, count/2 and (3*count)/4 respectively (integer division). Several bits may pulse together. Otherwise the bus is 0.
- R8: `busy_o` rises in the cycle after an accepted start and stays high until `done_o`. `done_o` lasts one cycle with `busy_o` low. A start while busy is ignored.
- R9: An error response to either set-phase access ends the sequence: there is no further access, `err_o` is 1 and `done_o` pulses.
- R10: An error response to a data write skips the remaining words and issues the clear read immediately. No milestone fires for that word, and `err_o` is 1 at `done_o`.
- R11: An error response to either clear-phase access ends the sequence with no further access and `err_o` 1. `err_o` returns to 0 on the next start.
- R12: While `bus_req_o` is high without `bus_ack_i` or `bus_err_i`, the request, address and direction are held in the next cycle.
- R13: With a count of 0, no data write and no milestone occur; the full control sequence still runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a sequence when idle |
| num_words_i | input | CNT_W | Number of words in the image |
| base_addr_i | input | ADDR_W | Byte address of the first EEPROM slot |
| ms_tick_i | input | 1 | One-cycle millisecond tick |
| src_idx_o | output | CNT_W | Index of the word being written |
| src_data_i | input | DATA_W | Source word at `src_idx_o`, same cycle |
| bus_req_o | output | 1 | Access request, held until response |
| bus_we_o | output | 1 | 1 for write, 0 for read |
| bus_addr_o | output | ADDR_W | Access address |
| bus_wdata_o | output | DATA_W | Write data |
| bus_ack_i | input | 1 | Access completed |
| bus_err_i | input | 1 | Access failed (takes priority over ack) |
| bus_rdata_i | input | DATA_W | Read data, valid with ack |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_o | output | 1 | Sequence ended on an error response |
| milestone_o | output | 3 | Quarter, half and three-quarter progress pulses |

## Verification
For small images, one word index can reach two or three progress thresholds at once. For example, a one-word image hits all three at index 0, and a two-word image hits half and three-quarters at index 1. The bench sweeps the count from 0 to 11 and compares every milestone pulse with thresholds computed by integer division. A second collision is an error response on a data write whose index would also fire a milestone. This is provoked by failing word 1 of a four-word image, and the check is that the pulse is withheld while the clear read follows at once.

// File: rtl/eps_pkg.sv
package eps_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_SET_RD,
    S_SET_WR,
    S_OPEN,
    S_DATA,
    S_GAP,
    S_CLR_RD,
    S_CLR_WR,
    S_CLOSE
  } eps_state_t;

  localparam int unsigned MS_COUNT = 3;
endpackage

// File: rtl/eps_timer.sv
module eps_timer #(
  parameter int unsigned TICK_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [TICK_W-1:0] count_i,
  input  logic              run_i,
  input  logic              tick_i,
  output logic              expire_o
);
  logic [TICK_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= count_i;
    end else if (run_i && tick_i && cnt_q != '0) begin
      cnt_q <= cnt_q - TICK_W'(1);
    end
  end

  assign expire_o = run_i && tick_i && (cnt_q == TICK_W'(1));

  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q != '0); // R5
endmodule

// File: rtl/eps_progress.sv
module eps_progress import eps_pkg::*; #(
  parameter int unsigned CNT_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CNT_W-1:0]    num_i,
  input  logic [CNT_W-1:0]    idx_i,
  input  logic                fire_i,
  output logic [MS_COUNT-1:0] ms_o
);
  localparam int unsigned EXT_W = CNT_W + 2;

  logic [EXT_W-1:0] num_ext, idx_ext;
  logic [EXT_W-1:0] thr [MS_COUNT];
  logic [MS_COUNT-1:0] hit;
  logic [MS_COUNT-1:0] ms_q;

  assign num_ext = EXT_W'(num_i);
  assign idx_ext = EXT_W'(idx_i);

  // thresholds at k/4 of the image, k = 1..MS_COUNT
  for (genvar k = 0; k < MS_COUNT; k++) begin : g_thr
    logic [EXT_W-1:0] scaled;
    assign scaled = num_ext * EXT_W'(k + 1);
    assign thr[k] = scaled >> 2;
    assign hit[k] = (idx_ext == thr[k]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ms_q <= '0;
    else         ms_q <= fire_i ? hit : '0;
  end

  assign ms_o = ms_q;

  AST_MS_AFTER_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ms_o) |-> $past(fire_i)); // R7
endmodule

// File: rtl/eeprom_prog_seq.sv
module eeprom_prog_seq import eps_pkg::*; #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned TICK_W      = 10,
  parameter int unsigned OPEN_TICKS  = 500,
  parameter int unsigned WORD_TICKS  = 20,
  parameter int unsigned CLOSE_TICKS = 500,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(16'h0088),
  parameter int unsigned WE_BIT      = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [CNT_W-1:0]    num_words_i,
  input  logic [ADDR_W-1:0]   base_addr_i,
  input  logic                ms_tick_i,
  output logic [CNT_W-1:0]    src_idx_o,
  input  logic [DATA_W-1:0]   src_data_i,
  output logic                bus_req_o,
  output logic                bus_we_o,
  output logic [ADDR_W-1:0]   bus_addr_o,
  output logic [DATA_W-1:0]   bus_wdata_o,
  input  logic                bus_ack_i,
  input  logic                bus_err_i,
  input  logic [DATA_W-1:0]   bus_rdata_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                err_o,
  output logic [MS_COUNT-1:0] milestone_o
);
  localparam int unsigned BYTE_STRIDE = DATA_W / 8;
  localparam logic [DATA_W-1:0] WE_MASK = DATA_W'(1) << WE_BIT;
  localparam logic [TICK_W-1:0] OPEN_CNT  = TICK_W'(OPEN_TICKS);
  localparam logic [TICK_W-1:0] WORD_CNT  = TICK_W'(WORD_TICKS);
  localparam logic [TICK_W-1:0] CLOSE_CNT = TICK_W'(CLOSE_TICKS);

  eps_state_t state_q, state_d;
  logic [CNT_W-1:0]  num_q, idx_q;
  logic [ADDR_W-1:0] base_q;
  logic [DATA_W-1:0] ctrl_q;
  logic              err_q, done_q;

  logic ack_ok, is_ctrl, is_wait;
  logic tmr_load, tmr_expire;
  logic [TICK_W-1:0] tmr_val;
  logic fire, abort, finish, data_fail;

  assign ack_ok  = bus_ack_i && !bus_err_i;
  assign is_ctrl = (state_q == S_SET_RD) || (state_q == S_SET_WR) ||
                   (state_q == S_CLR_RD) || (state_q == S_CLR_WR);
  assign is_wait = (state_q == S_OPEN) || (state_q == S_GAP) || (state_q == S_CLOSE);

  eps_timer #(.TICK_W(TICK_W)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tmr_load),
    .count_i  (tmr_val),
    .run_i    (is_wait),
    .tick_i   (ms_tick_i),
    .expire_o (tmr_expire)
  );

  eps_progress #(.CNT_W(CNT_W)) i_progress (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .num_i  (num_q),
    .idx_i  (idx_q),
    .fire_i (fire),
    .ms_o   (milestone_o)
  );

  always_comb begin
    state_d   = state_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    fire      = 1'b0;
    abort     = 1'b0;
    finish    = 1'b0;
    data_fail = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) state_d = S_SET_RD;
      S_SET_RD, S_SET_WR, S_CLR_RD, S_CLR_WR: begin
        if (bus_err_i) begin
          abort   = 1'b1;
          state_d = S_IDLE;
        end else if (bus_ack_i) begin
          unique case (state_q)
            S_SET_RD: state_d = S_SET_WR;
            S_SET_WR: begin
              state_d  = S_OPEN;
              tmr_load = 1'b1;
              tmr_val  = OPEN_CNT;
            end
            S_CLR_RD: state_d = S_CLR_WR;
            default: begin
              state_d  = S_CLOSE;
              tmr_load = 1'b1;
              tmr_val  = CLOSE_CNT;
            end
          endcase
        end
      end
      S_OPEN: if (tmr_expire) state_d = (num_q == '0) ? S_CLR_RD : S_DATA;
      S_DATA: begin
        if (bus_err_i) begin
          data_fail = 1'b1;
          state_d   = S_CLR_RD;
        end else if (bus_ack_i) begin
          fire     = 1'b1;
          state_d  = S_GAP;
          tmr_load = 1'b1;
          tmr_val  = WORD_CNT;
        end
      end
      S_GAP: if (tmr_expire) state_d = (idx_q == num_q) ? S_CLR_RD : S_DATA;
      S_CLOSE: if (tmr_expire) begin
        finish  = 1'b1;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      num_q   <= '0;
      idx_q   <= '0;
      base_q  <= '0;
      ctrl_q  <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= abort || finish;
      if (state_q == S_IDLE && start_i) begin
        num_q  <= num_words_i;
        base_q <= base_addr_i;
        idx_q  <= '0;
        err_q  <= 1'b0;
      end
      if (abort || data_fail) err_q <= 1'b1;
      if (state_q == S_SET_RD && ack_ok) ctrl_q <= bus_rdata_i | WE_MASK;
      if (state_q == S_CLR_RD && ack_ok) ctrl_q <= bus_rdata_i & ~WE_MASK;
      if (fire) idx_q <= idx_q + CNT_W'(1);
    end
  end

  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign src_idx_o   = idx_q;
  assign bus_req_o   = is_ctrl || (state_q == S_DATA);
  assign bus_we_o    = (state_q == S_SET_WR) || (state_q == S_CLR_WR) || (state_q == S_DATA);
  assign bus_addr_o  = (state_q == S_DATA) ?
                       base_q + ADDR_W'(idx_q) * ADDR_W'(BYTE_STRIDE) : CTRL_ADDR;
  assign bus_wdata_o = (state_q == S_DATA) ? src_data_i : ctrl_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i && !bus_err_i |=>
      bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o)); // R12
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R8
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o); // R8
  AST_SET_ERR_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == S_SET_RD) || (state_q == S_SET_WR)) && bus_err_i |=>
      !bus_req_o && err_o && done_o); // R9
  AST_DATA_ERR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DATA) && bus_err_i |=>
      bus_req_o && !bus_we_o && bus_addr_o == CTRL_ADDR && milestone_o == '0); // R10
endmodule

// File: tb/test_eeprom_prog_seq.sv
`timescale 1ns/1ps
module test_eeprom_prog_seq;
  localparam int DW = 16, AW = 16, CW = 6, TW = 8;
  localparam int OPEN_T = 5, WORD_T = 2, CLOSE_T = 4;
  localparam logic [15:0] CTRL_A = 16'h0040;
  localparam int WEB = 4;
  localparam logic [15:0] WEM = 16'h0010;

  logic clk_i = 1'b0;
  always #2 clk_i = ~clk_i;

  logic rst_ni = 1'b0, start = 1'b0, tick = 1'b0, ack = 1'b0, berr = 1'b0;
  logic [CW-1:0] num = '0;
  logic [AW-1:0] base = '0;
  logic [DW-1:0] rdata = '0;
  logic [CW-1:0] src_idx;
  logic [DW-1:0] src_data;
  logic bus_req, bus_we, busy, done, err;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [2:0] ms;
  logic [15:0] src_mem [0:63];

  assign src_data = src_mem[src_idx];

  eeprom_prog_seq #(
    .DATA_W(DW), .ADDR_W(AW), .CNT_W(CW), .TICK_W(TW),
    .OPEN_TICKS(OPEN_T), .WORD_TICKS(WORD_T), .CLOSE_TICKS(CLOSE_T),
    .CTRL_ADDR(CTRL_A), .WE_BIT(WEB)
  ) i_eeprom_prog_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .num_words_i(num),
    .base_addr_i(base), .ms_tick_i(tick), .src_idx_o(src_idx), .src_data_i(src_data),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
    .bus_ack_i(ack), .bus_err_i(berr), .bus_rdata_i(rdata),
    .busy_o(busy), .done_o(done), .err_o(err), .milestone_o(ms)
  );

  int n_tests = 0, n_fail = 0;
  logic [15:0] ctrl_reg = 16'h0;
  int err_k = -1, tick_div = 3, tick_cnt = 0, lat_cnt = 0, cur_lat = 1;
  int ticks_acc = 0, done_seen = 0, done_ticks = 0, data_cnt = 0, cur_n = 0;
  bit ms_pend = 0;
  int ms_idx = 0;
  bit prev_wait = 0;
  logic [15:0] prev_addr = '0;
  int lg_n = 0;
  int lg_we [0:31], lg_addr [0:31], lg_data [0:31], lg_ticks [0:31], lg_err [0:31];
  int e_n = 0;
  int e_we [0:31], e_addr [0:31], e_data [0:31], e_ticks [0:31], e_err [0:31];
  string e_tag [0:31], e_ttag [0:31];

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_ms(input int i, input int n);
    return {i == (3 * n) / 4, i == n / 2, i == n / 4};
  endfunction

  always @(negedge clk_i) begin
    automatic bit resp_now = ack || berr;
    automatic logic [2:0] ms_exp;
    if (resp_now) begin
      ack = 0; berr = 0; lat_cnt = 0;
    end else if (bus_req) begin
      if (lat_cnt >= cur_lat) begin
        if (lg_n == err_k) berr = 1; else ack = 1;
        rdata = ctrl_reg;
      end else lat_cnt++;
    end else lat_cnt = 0;
    tick_cnt++;
    tick = (tick_cnt % tick_div) == 0;
    if (rst_ni) begin
      ms_exp = ms_pend ? exp_ms(ms_idx, cur_n) : 3'b000;
      if (ms_exp != 0 || ms != 0) chk("R7", int'(ms), int'(ms_exp), "milestone bits");
      ms_pend = 0;
      if (prev_wait) chk("R12", int'({bus_req, bus_addr}), int'({1'b1, prev_addr}), "held request");
      prev_wait = bus_req && !ack && !berr;
      prev_addr = bus_addr;
      if (bus_req && (ack || berr)) begin
        if (lg_n < 32) begin
          lg_we[lg_n] = int'(bus_we);
          lg_addr[lg_n] = int'(bus_addr);
          lg_data[lg_n] = bus_we ? int'(bus_wdata) : int'(rdata);
          lg_ticks[lg_n] = ticks_acc;
          lg_err[lg_n] = int'(berr);
        end
        if (bus_we && ack && bus_addr == CTRL_A) ctrl_reg = bus_wdata;
        if (bus_we && ack && bus_addr != CTRL_A) begin
          ms_pend = 1; ms_idx = data_cnt; data_cnt++;
        end
        ticks_acc = 0;
        lg_n++;
        cur_lat = 1 + (lg_n % 3);
      end else if (tick && busy && !bus_req) ticks_acc++;
      if (done) begin
        done_seen++; done_ticks = ticks_acc;
      end
    end
  end

  task automatic add_exp(input int we, input int addr, input int data, input int t,
                         input int e, input string tag, input string ttag);
    e_we[e_n] = we; e_addr[e_n] = addr; e_data[e_n] = data;
    e_ticks[e_n] = t; e_err[e_n] = e; e_tag[e_n] = tag; e_ttag[e_n] = ttag;
    e_n++;
  endtask

  task automatic run_seq(input int n, input int b, input logic [15:0] c0, input int ea,
                         input int div, input bit restart);
    automatic int cyc = 0;
    automatic logic [15:0] cur;
    automatic int fin_ctrl, fin_err, fin_ticks, stop, derr;
    automatic string ctag;
    @(negedge clk_i);
    ctrl_reg = c0; err_k = ea; tick_div = div; lg_n = 0; ticks_acc = 0;
    done_seen = 0; data_cnt = 0; cur_n = n; cur_lat = 1;
    for (int i = 0; i < 64; i++) src_mem[i] = 16'(i * 16'h1357 + n * 16'h0101 + 16'h2468);
    num = CW'(n); base = AW'(b); start = 1;
    @(negedge clk_i);
    start = 0;
    chk("R8", int'(busy), 1, "busy after start");
    while (done_seen == 0 && cyc < 20000) begin
      @(negedge clk_i);
      cyc++;
      if (restart && cyc == 15) begin start = 1; num = CW'(n + 3); end
      else if (restart && cyc == 16) start = 0;
    end
    @(negedge clk_i);
    chk("R8", int'(done), 0, "done one cycle");
    chk("R8", int'(busy), 0, "idle after done");
    chk("R8", done_seen, 1, "done count");
    // expected access list
    e_n = 0; stop = 0; derr = 0; cur = c0 | WEM;
    fin_ctrl = int'(c0); fin_err = 1; fin_ticks = 0;
    add_exp(0, CTRL_A, c0, 0, int'(ea == 0), "R2", "R2");
    if (ea == 0) stop = 1;
    if (!stop) begin
      add_exp(1, CTRL_A, c0 | WEM, 0, int'(ea == 1), "R2", "R2");
      if (ea == 1) stop = 1;
    end
    if (!stop) begin
      for (int i = 0; i < n; i++) begin
        add_exp(1, (b + 2 * i) & 16'hffff, src_mem[i], (i == 0) ? OPEN_T : WORD_T,
                int'(e_n == ea), (e_n == ea) ? "R10" : "R4", (i == 0) ? "R3" : "R5");
        if (e_n - 1 == ea) begin derr = 1; break; end
      end
      add_exp(0, CTRL_A, cur, derr ? 0 : ((n == 0) ? OPEN_T : WORD_T), int'(e_n == ea),
              (n == 0) ? "R13" : "R6", derr ? "R10" : ((n == 0) ? "R3" : "R5"));
      if (e_n - 1 == ea) begin stop = 1; fin_ctrl = int'(cur); end
    end
    if (!stop) begin
      add_exp(1, CTRL_A, cur & ~WEM, 0, int'(e_n == ea), "R6", "R6");
      if (e_n - 1 == ea) begin stop = 1; fin_ctrl = int'(cur); end
      else begin fin_ctrl = int'(cur & ~WEM); fin_err = derr; fin_ticks = CLOSE_T; end
    end
    ctag = (ea < 0) ? ((n == 0) ? "R13" : "R4") : ((ea <= 1) ? "R9" : (derr ? "R10" : "R11"));
    chk(ctag, lg_n, e_n, "access count");
    for (int i = 0; i < e_n && i < lg_n && i < 32; i++) begin
      chk(e_tag[i], lg_we[i], e_we[i], "direction");
      chk(e_tag[i], lg_addr[i], e_addr[i], "address");
      chk(e_tag[i], lg_data[i], e_data[i], "data");
      chk(e_ttag[i], lg_ticks[i], e_ticks[i], "ticks before access");
      chk(ctag, lg_err[i], e_err[i], "error response");
    end
    chk((ea < 0) ? "R6" : ctag, done_ticks, fin_ticks, "ticks before done");
    chk((ea < 0) ? "R6" : ctag, int'(ctrl_reg), fin_ctrl, "final control value");
    chk((ea < 0) ? "R11" : ctag, int'(err), (ea < 0) ? 0 : fin_err, "error flag");
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL R8 watchdog expired: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) src_mem[i] = '0;
    repeat (3) @(negedge clk_i);
    chk("R1", int'({busy, done, err, bus_req, ms}), 0, "outputs in reset");
    rst_ni = 1;
    repeat (3) @(negedge clk_i);
    chk("R1", int'({busy, done, err, bus_req, ms}), 0, "outputs after reset");
    // clean sweep over image sizes
    for (int n = 0; n < 12; n++)
      run_seq(n, 16'h0100 + n * 16'h0020, 16'h0a00 ^ 16'(n * 16'h0111), -1, 2 + (n % 3), n == 7);
    // error responses at each phase of a four-word image
    run_seq(4, 16'h0200, 16'h1234, 0, 3, 0); // R9 set read
    run_seq(4, 16'h0200, 16'h1234, 1, 3, 0); // R9 set write
    run_seq(4, 16'h0200, 16'h1234, 2, 3, 0); // R10 word 0
    run_seq(4, 16'h0200, 16'h1234, 3, 2, 0); // R10 word 1, milestone collision
    run_seq(4, 16'h0200, 16'h1234, 5, 4, 0); // R10 last word
    run_seq(4, 16'h0200, 16'h1234, 6, 3, 0); // R11 clear read
    run_seq(4, 16'h0200, 16'h1234, 7, 3, 0); // R11 clear write
    run_seq(3, 16'h0300, 16'h00ff, -1, 3, 0); // R11 flag cleared by start
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule